// File: doc/BRIEF.md
# Low-Transition Pattern Generator for Built-In Self-Test

This block is the stimulus source of a logic self-test arrangement. A 36-bit maximal-length shift register with XOR feedback produces a sequence of base vectors. A plain generator would step straight from one base vector to the next. This generator instead walks there in four clocks through three intermediate vectors. The register is split into an upper half (bits 35:18) and a lower half (bits 17:0). The upper half moves first. Then an injector holds it for one clock while both halves rest. Finally the lower half moves. Every bit that differs between two base vectors toggles exactly once across the span, and no other bit toggles. The switching power in the circuit under test is therefore spread over more clocks, and no single step changes more than half of the pattern.

A four-state machine sequences the span. `PH_BASE` (code 0) shows the current base vector. `PH_HI` (code 1) shows the upper half of the next vector over the current lower half. `PH_INJ` (code 2) shows the injector's copy of that upper half over the held lower half. `PH_LO` (code 3) completes the lower half. The transitions are BASE→HI, HI→INJ, INJ→LO and LO→BASE, and each is taken on an enabled clock. The shift register advances only on the LO→BASE transition. A seed load forces any state to `PH_BASE`. The output pattern is built in two levels. The first level picks the present or the next state of each register bit. The second level picks either that value or the injector's held value.

Top module: `lt_tpg`

## Requirements
- R1: After reset, `pattern` equals the default seed 36'h4A5AD296B (binary 010010100101101011010010100101101011, MSB first), `phase` is 0 and `base_strobe` is 1.
- R2: On each clock with `en` high and `seed_load` low, `phase` steps 0→1→2→3→0. `base_strobe` is high exactly when `phase` is 0.
- R3: On a clock with `en` low and `seed_load` low, `pattern` and `phase` keep their values.
- R4: The vectors shown while `phase` is 0 follow a Fibonacci shift register that shifts toward the MSB. The new bit 0 is bit 35 XOR bit 24 (polynomial x^36 + x^25 + 1). The register advances once per four enabled clocks.
- R5: In phase 1, bits 35:18 equal the next base vector and bits 17:0 equal the current base vector.
- R6: In phase 2, the pattern is identical to the phase-1 pattern. The upper half comes from the injector and the lower half is held.
- R7: In phase 3, the pattern equals the next base vector. The following phase-0 pattern repeats it.
- R8: Over one span, the sum of the bit differences between successive patterns equals the Hamming distance between the two base vectors. No single step differs in more than 18 bits.
- R9: A clock with `seed_load` high loads `seed_val` as the base vector and sets `phase` to 0, whatever `en` and the current phase are.
- R10: A load of an all-zero `seed_val` loads the default seed 36'h4A5AD296B instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Advance the phase (and, on wrap, the base register) |
| seed_load | input | 1 | Load `seed_val` on this clock; takes priority over `en` |
| seed_val | input | 36 | Seed for the base register |
| pattern | output | 36 | Test pattern driven to the circuit under test |
| base_strobe | output | 1 | High while a base vector is shown |
| phase | output | 2 | Current phase: 0 base, 1 upper moved, 2 injected, 3 lower moved |

## Verification
The bench runs many consecutive spans against an independent model of the shift register. If the upper and lower halves were swapped, the check on which half moves in phase 1 would fail. An injector that captured the current rather than the next upper half would add toggles, and the per-span transition sum would come out larger than the Hamming distance of the base step. Feedback taken from the wrong tap breaks the match with the model within a few spans. Two loads are aimed at the seed logic. A load in the middle of a span must leave no stale phase behind. A load of zero must not lock the register at zero.

// File: rtl/lt_tpg_pkg.sv
package lt_tpg_pkg;

    typedef enum logic [1:0] {
        PH_BASE = 2'd0,
        PH_HI   = 2'd1,
        PH_INJ  = 2'd2,
        PH_LO   = 2'd3
    } phase_e;

    typedef struct packed {
        logic hi_next;
        logic hi_inj;
        logic lo_next;
        logic inj_cap;
        logic base_adv;
    } sel_t;

endpackage

// File: rtl/lt_lfsr_core.sv
module lt_lfsr_core #(
    parameter int              WIDTH = 36,
    parameter int              TAP   = 25,
    parameter logic [WIDTH-1:0] SEED = 36'h4A5AD296B
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    input  logic             load,
    input  logic [WIDTH-1:0] seed_in,
    output logic [WIDTH-1:0] cur,
    output logic [WIDTH-1:0] nxt
);
    logic             fb;
    logic [WIDTH-1:0] load_val;

    assign fb       = cur[WIDTH-1] ^ cur[TAP-1];
    assign nxt      = {cur[WIDTH-2:0], fb};
    assign load_val = (seed_in == '0) ? SEED : seed_in;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur <= SEED;
        end else if (load) begin
            cur <= load_val;
        end else if (adv) begin
            cur <= nxt;
        end
    end
endmodule

// File: rtl/lt_phase_fsm.sv
module lt_phase_fsm
    import lt_tpg_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   en,
    input  logic   load,
    output phase_e state,
    output sel_t   ctl
);
    phase_e state_nxt;
    logic   step;

    assign step = en && !load;

    always_comb begin
        state_nxt = state;
        unique case (state)
            PH_BASE: state_nxt = PH_HI;
            PH_HI:   state_nxt = PH_INJ;
            PH_INJ:  state_nxt = PH_LO;
            PH_LO:   state_nxt = PH_BASE;
            default: state_nxt = PH_BASE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= PH_BASE;
        end else if (load) begin
            state <= PH_BASE;
        end else if (en) begin
            state <= state_nxt;
        end
    end

    always_comb begin
        ctl = '0;
        unique case (state)
            PH_BASE: begin
                ctl = '0;
            end
            PH_HI: begin
                ctl.hi_next = 1'b1;
                ctl.inj_cap = step;
            end
            PH_INJ: begin
                ctl.hi_inj = 1'b1;
            end
            PH_LO: begin
                ctl.hi_next  = 1'b1;
                ctl.lo_next  = 1'b1;
                ctl.base_adv = step;
            end
            default: ctl = '0;
        endcase
    end
endmodule

// File: rtl/lt_injector.sv
module lt_injector #(
    parameter int HW = 18
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cap,
    input  logic [HW-1:0] d,
    output logic [HW-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (cap) begin
            q <= d;
        end
    end
endmodule

// File: rtl/lt_pattern_mux.sv
module lt_pattern_mux
    import lt_tpg_pkg::*;
#(
    parameter int WIDTH = 36,
    parameter int HW    = 18
) (
    input  logic [WIDTH-1:0] cur,
    input  logic [WIDTH-1:0] nxt,
    input  logic [HW-1:0]    inj,
    input  sel_t             ctl,
    output logic [WIDTH-1:0] pattern
);
    localparam int LO = WIDTH - HW;

    logic [WIDTH-1:0] lvl1;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        if (i >= LO) begin : g_hi
            assign lvl1[i]    = ctl.hi_next ? nxt[i] : cur[i];
            assign pattern[i] = ctl.hi_inj ? inj[i-LO] : lvl1[i];
        end else begin : g_lo
            assign lvl1[i]    = ctl.lo_next ? nxt[i] : cur[i];
            assign pattern[i] = lvl1[i];
        end
    end
endmodule

// File: rtl/lt_tpg.sv
module lt_tpg
    import lt_tpg_pkg::*;
#(
    parameter int               WIDTH = 36,
    parameter int               TAP   = 25,
    parameter logic [WIDTH-1:0] SEED  = 36'h4A5AD296B
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             seed_load,
    input  logic [WIDTH-1:0] seed_val,
    output logic [WIDTH-1:0] pattern,
    output logic             base_strobe,
    output logic [1:0]       phase
);
    localparam int HW = WIDTH / 2;
    localparam int LO = WIDTH - HW;

    phase_e           state;
    sel_t             ctl;
    logic [WIDTH-1:0] cur;
    logic [WIDTH-1:0] nxt;
    logic [HW-1:0]    inj_q;

    lt_phase_fsm u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (en),
        .load  (seed_load),
        .state (state),
        .ctl   (ctl)
    );

    lt_lfsr_core #(.WIDTH(WIDTH), .TAP(TAP), .SEED(SEED)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv     (ctl.base_adv),
        .load    (seed_load),
        .seed_in (seed_val),
        .cur     (cur),
        .nxt     (nxt)
    );

    lt_injector #(.HW(HW)) u_inj (
        .clk   (clk),
        .rst_n (rst_n),
        .cap   (ctl.inj_cap),
        .d     (nxt[WIDTH-1:LO]),
        .q     (inj_q)
    );

    lt_pattern_mux #(.WIDTH(WIDTH), .HW(HW)) u_mux (
        .cur     (cur),
        .nxt     (nxt),
        .inj     (inj_q),
        .ctl     (ctl),
        .pattern (pattern)
    );

    assign phase       = state;
    assign base_strobe = (state == PH_BASE);
endmodule

// File: rtl/lt_tpg_checker.sv
module lt_tpg_checker #(
    parameter int WIDTH = 36
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en,
    input logic             seed_load,
    input logic [WIDTH-1:0] pattern,
    input logic             base_strobe,
    input logic [1:0]       phase
);
    localparam int HW = WIDTH / 2;
    localparam int LO = WIDTH - HW;

    logic step;
    assign step = en && !seed_load;

    AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> phase == 2'($past(phase) + 2'd1)); // R2

    AST_STROBE_BASE: assert property (@(posedge clk) disable iff (!rst_n)
        base_strobe == (phase == 2'd0)); // R2

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !seed_load) |=> ($stable(pattern) && $stable(phase))); // R3

    AST_LO_HELD_IN_HI: assert property (@(posedge clk) disable iff (!rst_n)
        (step && phase == 2'd0) |=> $stable(pattern[LO-1:0])); // R5

    AST_INJ_SAME: assert property (@(posedge clk) disable iff (!rst_n)
        (step && phase == 2'd1) |=> $stable(pattern)); // R6

    AST_HI_HELD_IN_LO: assert property (@(posedge clk) disable iff (!rst_n)
        (step && phase == 2'd2) |=> $stable(pattern[WIDTH-1:LO])); // R7

    AST_BASE_REPEAT: assert property (@(posedge clk) disable iff (!rst_n)
        (step && phase == 2'd3) |=> $stable(pattern)); // R7

    AST_STEP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> $countones(pattern ^ $past(pattern)) <= HW); // R8

    AST_LOAD_BASE: assert property (@(posedge clk) disable iff (!rst_n)
        seed_load |=> (phase == 2'd0 && base_strobe)); // R9

    AST_NO_LOCKUP: assert property (@(posedge clk) disable iff (!rst_n)
        base_strobe |-> pattern != '0); // R10
endmodule

bind lt_tpg lt_tpg_checker #(.WIDTH(WIDTH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .en          (en),
    .seed_load   (seed_load),
    .pattern     (pattern),
    .base_strobe (base_strobe),
    .phase       (phase)
);

// File: tb/lt_tpg_bench.sv
`timescale 1ns/1ps
module lt_tpg_bench;
    localparam logic [35:0] DEF = 36'h4A5AD296B;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic        seed_load = 1'b0;
    logic [35:0] seed_val = '0;
    logic [35:0] pattern;
    logic        base_strobe;
    logic [1:0]  phase;

    int n_checks = 0;
    int n_fail = 0;
    logic [35:0] model;

    always #10 clk = ~clk;

    lt_tpg u_lt_tpg (
        .clk         (clk),
        .rst_n       (rst_n),
        .en          (en),
        .seed_load   (seed_load),
        .seed_val    (seed_val),
        .pattern     (pattern),
        .base_strobe (base_strobe),
        .phase       (phase)
    );

    function automatic logic [35:0] step_ref(input logic [35:0] s);
        return {s[34:0], s[35] ^ s[24]};
    endfunction

    function automatic int hd(input logic [35:0] a, input logic [35:0] b);
        return $countones(a ^ b);
    endfunction

    task automatic chk(input bit ok, input string req,
                       input logic [35:0] act, input logic [35:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic load_seed(input logic [35:0] s, input logic e);
        seed_load = 1'b1;
        seed_val  = s;
        en        = e;
        cyc();
        seed_load = 1'b0;
        model = (s == '0) ? DEF : s;
    endtask

    task automatic t_reset();
        chk(pattern == DEF, "R1 pattern", pattern, DEF);
        chk(phase == 2'd0, "R1 phase", 36'(phase), 36'd0);
        chk(base_strobe == 1'b1, "R1 strobe", 36'(base_strobe), 36'd1);
    endtask

    task automatic t_phase_walk();
        load_seed(36'h123456789, 1'b0);
        en = 1'b1;
        for (int k = 1; k <= 8; k++) begin
            cyc();
            chk(phase == 2'(k % 4), "R2 phase order", 36'(phase), 36'(k % 4));
            chk(base_strobe == (k % 4 == 0), "R2 strobe", 36'(base_strobe),
                36'(k % 4 == 0));
        end
        en = 1'b0;
    endtask

    task automatic t_hold();
        logic [35:0] p;
        load_seed(36'hF0F0F0F0F, 1'b0);
        en = 1'b1;
        cyc();
        p = pattern;
        en = 1'b0;
        for (int k = 0; k < 3; k++) begin
            cyc();
            chk(pattern == p, "R3 pattern held", pattern, p);
            chk(phase == 2'd1, "R3 phase held", 36'(phase), 36'd1);
        end
        en = 1'b1;
        cyc();
        chk(phase == 2'd2, "R3 resume", 36'(phase), 36'd2);
        en = 1'b0;
    endtask

    task automatic t_spans(input logic [35:0] s, input int n);
        logic [35:0] t1, t2, ta, tb, tc;
        int sum;
        load_seed(s, 1'b0);
        en = 1'b1;
        for (int k = 0; k < n; k++) begin
            t1 = pattern;
            t2 = step_ref(model);
            chk(t1 == model && base_strobe, "R4 base vector", t1, model);
            cyc();
            ta = pattern;
            chk(ta == {t2[35:18], t1[17:0]}, "R5 upper half moved", ta,
                {t2[35:18], t1[17:0]});
            cyc();
            tb = pattern;
            chk(tb == ta, "R6 injected vector", tb, ta);
            cyc();
            tc = pattern;
            chk(tc == t2, "R7 lower half completed", tc, t2);
            cyc();
            chk(pattern == t2 && base_strobe, "R7 next base repeats", pattern, t2);
            sum = hd(t1, ta) + hd(ta, tb) + hd(tb, tc) + hd(tc, pattern);
            chk(sum == hd(t1, t2), "R8 transition sum", 36'(sum), 36'(hd(t1, t2)));
            chk(hd(t1, ta) <= 18 && hd(tb, tc) <= 18, "R8 step bound",
                36'(hd(t1, ta)), 36'(hd(tb, tc)));
            model = t2;
        end
        en = 1'b0;
    endtask

    task automatic t_seed_load();
        load_seed(36'hABCDE1234, 1'b0);
        en = 1'b1;
        cyc();
        cyc();
        chk(phase == 2'd2, "R9 mid span", 36'(phase), 36'd2);
        load_seed(36'h00000FFFF, 1'b1);
        chk(pattern == 36'h00000FFFF, "R9 load mid span", pattern, 36'h00000FFFF);
        chk(phase == 2'd0 && base_strobe, "R9 phase reset", 36'(phase), 36'd0);
        en = 1'b0;
        load_seed(36'h800000001, 1'b0);
        chk(pattern == 36'h800000001, "R9 load while idle", pattern, 36'h800000001);
    endtask

    task automatic t_zero_seed();
        load_seed(36'h0, 1'b0);
        chk(pattern == DEF, "R10 zero seed replaced", pattern, DEF);
        en = 1'b1;
        repeat (4) cyc();
        en = 1'b0;
        chk(pattern == step_ref(DEF), "R10 runs after zero load", pattern,
            step_ref(DEF));
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures",
                 n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        report();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_phase_walk();
        t_hold();
        t_spans(DEF, 40);
        t_spans(36'h000000001, 40);
        t_spans(36'hFFFFFFFFF, 20);
        t_seed_load();
        t_zero_seed();
        report();
    end
endmodule